// File: doc/BRIEF.md
# Low-Power Mode Controller

This block steps a small processor subsystem through four power modes: active, sleep, deep sleep and standby. The core asks for a low-power mode with a one-cycle wait-for-interrupt pulse or a one-cycle wait-for-event pulse. A deep-select bit chooses light sleep or deep sleep for the interrupt path. The event path always leads to standby. An active-low hold input can postpone entry for as long as it stays low. While entry is held back, any wakeup cancels the request.

The outputs are the enables that the surrounding clock-gating cells and SRAM power switch consume: one core clock enable, one enable per peripheral, and one SRAM power enable. There is also a one-cycle wakeup acknowledge, a one-cycle sleep-exit strobe and a 2-bit mode report. On leaving deep sleep or standby, SRAM power comes back one cycle before the clocks. All pins are plain level or strobe controls, so the block has no valid/ready handshake and no back-pressure.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (active), core_clk_en_o is 1, every periph_clk_en_o bit is 1, sram_pwr_en_o is 1, and wake_ack_o and sleep_exit_o are 0.
- R2: In active with hold_n_i high, a wfi_i pulse makes mode_o 1 (sleep) when deep_sel_i is 0 and 2 (deep sleep) when it is 1. A wfe_i pulse makes mode_o 3 (standby). When wfe_i and wfi_i arrive together, wfe_i wins. The new mode shows after the clock edge that samples the pulse.
- R3: If hold_n_i is low when a request is sampled, mode_o stays 0 and all enables stay on for as long as hold_n_i is low. Entry takes effect after the first edge that samples hold_n_i high.
- R4: While entry is held back, a wakeup cancels it. A wakeup is any wake_irq_i bit, or ext_evt_i. After a cancel the block remains active, wake_ack_o stays 0, and a later release of the hold does not enter any low-power mode.
- R5: In sleep (mode 1), core_clk_en_o is 0, while all peripheral enables and sram_pwr_en_o stay 1.
- R6: In deep sleep (mode 2), core_clk_en_o and all peripheral enables are 0. sram_pwr_en_o equals the ret_en_i value sampled on the entry edge.
- R7: In standby (mode 3), core_clk_en_o, all peripheral enables and sram_pwr_en_o are 0.
- R8: Sleep wakes only on a wake_irq_i bit. Deep sleep wakes on a wake_irq_i bit or on ext_evt_i. Standby wakes only on ext_evt_i. Any other input leaves the mode and the enables unchanged.
- R9: Leaving sleep happens on the edge that samples the wakeup. After that edge, mode_o is 0, all enables are 1, and wake_ack_o and sleep_exit_o are both 1 for exactly one cycle.
- R10: Leaving deep sleep or standby takes two edges. After the first edge, wake_ack_o is 1, sram_pwr_en_o is 1, the clocks are still off and mode_o still shows the old mode. After the second edge, mode_o is 0, all clock enables are 1, sleep_exit_o is 1, and wake_ack_o is 0. Each strobe lasts one cycle.
- R11: wfi_i and wfe_i are ignored outside active. Wakeup inputs are ignored in active when no entry is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wfi_i | input | 1 | One-cycle wait-for-interrupt request |
| wfe_i | input | 1 | One-cycle wait-for-event request |
| deep_sel_i | input | 1 | 1 selects deep sleep for wfi_i, 0 selects sleep |
| hold_n_i | input | 1 | Active-low hold that postpones entry |
| ret_en_i | input | 1 | Keep SRAM powered in deep sleep |
| wake_irq_i | input | N_IRQ | Wakeup interrupt lines |
| ext_evt_i | input | 1 | External wakeup event |
| core_clk_en_o | output | 1 | Core clock enable |
| periph_clk_en_o | output | N_PERIPH | Peripheral clock enables |
| sram_pwr_en_o | output | 1 | SRAM power enable |
| wake_ack_o | output | 1 | Wakeup accepted strobe |
| sleep_exit_o | output | 1 | Strobe in the first cycle with clocks back |
| mode_o | output | 2 | 0 active, 1 sleep, 2 deep sleep, 3 standby |

## Verification
Every output is a decode of registered state. Entry and sleep exit therefore show one edge after the sampled request or wakeup. Exits from deep sleep and standby take two edges: the acknowledge and SRAM power appear after the first, and the clocks, mode 0 and the exit strobe after the second. The bench drives inputs on the falling edge and samples outputs at the next falling edge, one rising edge later, so each check lands in exactly the cycle its result is due.

The bench sweeps every request kind against both retention settings, both hold settings and every wakeup source. For each combination it computes the expected mode, the enables and whether the input should wake the block. It then follows the strobes cycle by cycle.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE  = 2'd0,
    MODE_SLEEP   = 2'd1,
    MODE_DEEP    = 2'd2,
    MODE_STANDBY = 2'd3
  } pwr_mode_e;

  typedef enum logic [2:0] {
    S_RUN  = 3'd0,
    S_PEND = 3'd1,
    S_SLP  = 3'd2,
    S_DSLP = 3'd3,
    S_STBY = 3'd4,
    S_RSTR = 3'd5
  } seq_state_e;

endpackage

// File: rtl/pwr_wake_sense.sv
module pwr_wake_sense
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ = 3
) (
  input  logic [N_IRQ-1:0] wake_irq_i,
  input  logic             ext_evt_i,
  input  seq_state_e       state_i,
  output logic             wake_take_o
);

  logic irq_any;

  assign irq_any = |wake_irq_i;

  // Which sources count as a wakeup depends on the current state.
  always_comb begin
    unique case (state_i)
      S_PEND:  wake_take_o = irq_any | ext_evt_i;
      S_SLP:   wake_take_o = irq_any;
      S_DSLP:  wake_take_o = irq_any | ext_evt_i;
      S_STBY:  wake_take_o = ext_evt_i;
      default: wake_take_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wfi_i,
  input  logic       wfe_i,
  input  logic       deep_sel_i,
  input  logic       hold_n_i,
  input  logic       ret_en_i,
  input  logic       wake_take_i,
  output seq_state_e state_o,
  output logic       ret_o,
  output pwr_mode_e  from_mode_o,
  output logic       ack_o,
  output logic       exit_o
);

  seq_state_e state_q, state_d;
  seq_state_e tgt_q, tgt_d;
  seq_state_e req_tgt;
  logic       ret_q, ret_d;
  pwr_mode_e  from_q, from_d;
  logic       ack_d, exit_d;
  logic       ack_q, exit_q;

  // Event requests take priority over interrupt requests.
  always_comb begin
    if (wfe_i)           req_tgt = S_STBY;
    else if (deep_sel_i) req_tgt = S_DSLP;
    else                 req_tgt = S_SLP;
  end

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    from_d  = from_q;
    ack_d   = 1'b0;
    exit_d  = 1'b0;
    unique case (state_q)
      S_RUN: begin
        if (wfi_i || wfe_i) begin
          if (hold_n_i) begin
            state_d = req_tgt;
          end else begin
            state_d = S_PEND;
            tgt_d   = req_tgt;
          end
        end
      end
      S_PEND: begin
        if (wake_take_i)   state_d = S_RUN;
        else if (hold_n_i) state_d = tgt_q;
      end
      S_SLP: begin
        if (wake_take_i) begin
          state_d = S_RUN;
          ack_d   = 1'b1;
          exit_d  = 1'b1;
        end
      end
      S_DSLP: begin
        if (wake_take_i) begin
          state_d = S_RSTR;
          ack_d   = 1'b1;
          from_d  = MODE_DEEP;
        end
      end
      S_STBY: begin
        if (wake_take_i) begin
          state_d = S_RSTR;
          ack_d   = 1'b1;
          from_d  = MODE_STANDBY;
        end
      end
      S_RSTR: begin
        state_d = S_RUN;
        exit_d  = 1'b1;
      end
      default: state_d = S_RUN;
    endcase
  end

  // The retention bit is captured on the edge that enters deep sleep.
  always_comb begin
    ret_d = ret_q;
    if (state_d == S_DSLP && state_q != S_DSLP) ret_d = ret_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_RUN;
      tgt_q   <= S_SLP;
      ret_q   <= 1'b1;
      from_q  <= MODE_ACTIVE;
      ack_q   <= 1'b0;
      exit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      ret_q   <= ret_d;
      from_q  <= from_d;
      ack_q   <= ack_d;
      exit_q  <= exit_d;
    end
  end

  assign state_o     = state_q;
  assign ret_o       = ret_q;
  assign from_mode_o = from_q;
  assign ack_o       = ack_q;
  assign exit_o      = exit_q;

  // R2
  wfe_to_standby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RUN && wfe_i && hold_n_i) |=> (state_q == S_STBY));

  // R4
  pend_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PEND && wake_take_i) |=> (state_q == S_RUN && !ack_q));

  // R10
  restore_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RSTR) |=> (state_q == S_RUN && exit_q));

  // R11
  run_ignores_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RUN && !wfi_i && !wfe_i) |=> (state_q == S_RUN && !ack_q));

endmodule

// File: rtl/pwr_enable_map.sv
module pwr_enable_map
  import pwr_mode_pkg::*;
#(
  parameter int N_PERIPH = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  seq_state_e          state_i,
  input  logic                ret_i,
  input  pwr_mode_e           from_mode_i,
  output logic                core_en_o,
  output logic [N_PERIPH-1:0] periph_en_o,
  output logic                sram_en_o,
  output pwr_mode_e           mode_o
);

  localparam logic [N_PERIPH-1:0] ALL_ON = {N_PERIPH{1'b1}};

  logic periph_on;

  always_comb begin
    core_en_o = 1'b1;
    periph_on = 1'b1;
    sram_en_o = 1'b1;
    mode_o    = MODE_ACTIVE;
    unique case (state_i)
      S_SLP: begin
        core_en_o = 1'b0;
        mode_o    = MODE_SLEEP;
      end
      S_DSLP: begin
        core_en_o = 1'b0;
        periph_on = 1'b0;
        sram_en_o = ret_i;
        mode_o    = MODE_DEEP;
      end
      S_STBY: begin
        core_en_o = 1'b0;
        periph_on = 1'b0;
        sram_en_o = 1'b0;
        mode_o    = MODE_STANDBY;
      end
      S_RSTR: begin
        core_en_o = 1'b0;
        periph_on = 1'b0;
        mode_o    = from_mode_i;
      end
      default: ;
    endcase
  end

  for (genvar gi = 0; gi < N_PERIPH; gi++) begin : g_periph
    assign periph_en_o[gi] = periph_on;
  end

  // R5
  sleep_keeps_periph_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_SLP) |-> (!core_en_o && periph_en_o == ALL_ON && sram_en_o));

  // R6
  deep_clocks_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_DSLP) |-> (!core_en_o && periph_en_o == '0));

  // R7
  standby_all_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_STANDBY && state_i != S_RSTR) |-> (!core_en_o && periph_en_o == '0 && !sram_en_o));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ    = 3,
  parameter int N_PERIPH = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wfi_i,
  input  logic                wfe_i,
  input  logic                deep_sel_i,
  input  logic                hold_n_i,
  input  logic                ret_en_i,
  input  logic [N_IRQ-1:0]    wake_irq_i,
  input  logic                ext_evt_i,
  output logic                core_clk_en_o,
  output logic [N_PERIPH-1:0] periph_clk_en_o,
  output logic                sram_pwr_en_o,
  output logic                wake_ack_o,
  output logic                sleep_exit_o,
  output logic [1:0]          mode_o
);

  seq_state_e state;
  logic       wake_take;
  logic       ret_keep;
  pwr_mode_e  from_mode;
  pwr_mode_e  mode_enc;

  pwr_wake_sense #(.N_IRQ(N_IRQ)) u_wake (
    .wake_irq_i  (wake_irq_i),
    .ext_evt_i   (ext_evt_i),
    .state_i     (state),
    .wake_take_o (wake_take)
  );

  pwr_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wfi_i       (wfi_i),
    .wfe_i       (wfe_i),
    .deep_sel_i  (deep_sel_i),
    .hold_n_i    (hold_n_i),
    .ret_en_i    (ret_en_i),
    .wake_take_i (wake_take),
    .state_o     (state),
    .ret_o       (ret_keep),
    .from_mode_o (from_mode),
    .ack_o       (wake_ack_o),
    .exit_o      (sleep_exit_o)
  );

  pwr_enable_map #(.N_PERIPH(N_PERIPH)) u_map (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .ret_i       (ret_keep),
    .from_mode_i (from_mode),
    .core_en_o   (core_clk_en_o),
    .periph_en_o (periph_clk_en_o),
    .sram_en_o   (sram_pwr_en_o),
    .mode_o      (mode_enc)
  );

  assign mode_o = mode_enc;

  // R9
  sleep_exit_same_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_ack_o && core_clk_en_o) |-> (sleep_exit_o && mode_o == 2'd0));

  // R10
  clocks_after_sram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_ack_o && !core_clk_en_o) |-> sram_pwr_en_o);

  // R10
  deep_exit_second_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_ack_o && !core_clk_en_o) |=> (core_clk_en_o && sleep_exit_o && !wake_ack_o));

  // R9
  exit_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_exit_o |=> !sleep_exit_o);

endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

  localparam int NI = 3;
  localparam int NP = 4;
  localparam int ALL_P = (1 << NP) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wfi = 1'b0, wfe = 1'b0, deep_sel = 1'b0, hold_n = 1'b1, ret_en = 1'b0;
  logic [NI-1:0] irq = '0;
  logic          ext = 1'b0;
  logic          core_en, sram_en, ack, sexit;
  logic [NP-1:0] periph_en;
  logic [1:0]    mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.N_IRQ(NI), .N_PERIPH(NP)) u_pwr_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wfi_i(wfi), .wfe_i(wfe), .deep_sel_i(deep_sel),
    .hold_n_i(hold_n), .ret_en_i(ret_en), .wake_irq_i(irq), .ext_evt_i(ext),
    .core_clk_en_o(core_en), .periph_clk_en_o(periph_en), .sram_pwr_en_o(sram_en),
    .wake_ack_o(ack), .sleep_exit_o(sexit), .mode_o(mode)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk_outs(input string req, input int m, input int c, input int p,
                          input int s, input int a, input int x);
    chk(req, "mode", int'(mode), m);
    chk(req, "core_en", int'(core_en), c);
    chk(req, "periph_en", int'(periph_en), p);
    chk(req, "sram_en", int'(sram_en), s);
    chk(req, "wake_ack", int'(ack), a);
    chk(req, "sleep_exit", int'(sexit), x);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int exp_mode, exp_sram, exp_p;
    bit wakes;
    repeat (3) cyc();
    // R1 reset state
    chk_outs("R1", 0, 1, ALL_P, 1, 0, 0);
    rst_n = 1'b1;
    cyc();
    chk_outs("R1", 0, 1, ALL_P, 1, 0, 0);

    // R11 wakeups in active are ignored
    irq = 3'b101; ext = 1'b1;
    cyc();
    irq = '0; ext = 1'b0;
    chk_outs("R11", 0, 1, ALL_P, 1, 0, 0);

    // R2 both requests together: standby wins
    wfi = 1'b1; wfe = 1'b1; deep_sel = 1'b1;
    cyc();
    wfi = 1'b0; wfe = 1'b0;
    chk_outs("R2", 3, 0, 0, 0, 0, 0);
    ext = 1'b1; cyc(); ext = 1'b0;
    cyc();
    chk_outs("R10", 0, 1, ALL_P, 1, 0, 1);
    cyc();

    // R4 cancel of held entry by interrupt, then by event
    for (int k = 0; k < 2; k++) begin
      hold_n = 1'b0; deep_sel = 1'b0;
      if (k == 0) wfi = 1'b1; else wfe = 1'b1;
      cyc();
      wfi = 1'b0; wfe = 1'b0;
      chk_outs("R3", 0, 1, ALL_P, 1, 0, 0);
      if (k == 0) irq[1] = 1'b1; else ext = 1'b1;
      cyc();
      irq = '0; ext = 1'b0;
      chk_outs("R4", 0, 1, ALL_P, 1, 0, 0);
      hold_n = 1'b1;
      cyc();
      chk_outs("R4", 0, 1, ALL_P, 1, 0, 0);
    end

    // Sweep: request kind x retention x hold length x wake source
    for (int kind = 0; kind < 3; kind++) begin
      for (int ret = 0; ret < 2; ret++) begin
        for (int hc = 0; hc < 3; hc += 2) begin
          for (int src = 0; src <= NI; src++) begin
            deep_sel = (kind == 1);
            ret_en   = ret[0];
            hold_n   = (hc == 0);
            if (kind == 2) wfe = 1'b1; else wfi = 1'b1;
            cyc();
            wfi = 1'b0; wfe = 1'b0;
            for (int h = 0; h < hc; h++) begin
              chk_outs("R3", 0, 1, ALL_P, 1, 0, 0);
              cyc();
            end
            if (hc > 0) begin
              hold_n = 1'b1;
              cyc();
            end
            exp_mode = kind + 1;
            exp_sram = (kind == 0) ? 1 : (kind == 1) ? ret : 0;
            exp_p    = (kind == 0) ? ALL_P : 0;
            chk_outs(kind == 0 ? "R5" : kind == 1 ? "R6" : "R7",
                     exp_mode, 0, exp_p, exp_sram, 0, 0);
            // R11 requests ignored in a low-power mode
            wfi = 1'b1; wfe = 1'b1;
            cyc();
            wfi = 1'b0; wfe = 1'b0;
            chk_outs("R11", exp_mode, 0, exp_p, exp_sram, 0, 0);
            // R8 wake attempt
            if (src < NI) irq[src] = 1'b1; else ext = 1'b1;
            cyc();
            irq = '0; ext = 1'b0;
            wakes = (kind == 0) ? (src < NI) : (kind == 1) ? 1'b1 : (src == NI);
            if (!wakes) begin
              chk_outs("R8", exp_mode, 0, exp_p, exp_sram, 0, 0);
              if (kind == 0) irq[0] = 1'b1; else ext = 1'b1;
              cyc();
              irq = '0; ext = 1'b0;
            end
            if (kind == 0) begin
              chk_outs("R9", 0, 1, ALL_P, 1, 1, 1);
              cyc();
              chk_outs("R9", 0, 1, ALL_P, 1, 0, 0);
            end else begin
              chk_outs("R10", exp_mode, 0, 0, 1, 1, 0);
              cyc();
              chk_outs("R10", 0, 1, ALL_P, 1, 0, 1);
              cyc();
              chk_outs("R10", 0, 1, ALL_P, 1, 0, 0);
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule